// File: doc/BRIEF.md
# Run-Time Mode SPI Master Shifter

This block moves one byte at a time over a four-wire serial link and acts as the link master. A host pulses a start input with a byte to send. The block then pulls slave select low. It toggles the serial clock sixteen times, shifts the byte out on MOSI, collects one byte from MISO, and raises slave select again. Last, it pulses a done flag, and the received byte is then valid on its own output.

Clock polarity, clock phase and bit order are plain inputs, so every frame can use any of the four SPI modes in either bit order. The block captures these settings, and the divider, when it accepts a start. Changing them during a frame has no effect. The half-period of the serial clock is a count of system clocks. The received byte always comes out with bit 7 as the most significant bit, whichever order was used on the wire.

Top module: `spi_mode_master`

## Requirements
- R1: After reset, and whenever no frame is active, `ss_n_o` is 1, `busy_o` and `done_o` are 0, and `sck_o` equals the live `cpol_i` level.
- R2: A `start_i` seen at a clock edge while idle makes `busy_o` 1 and `ss_n_o` 0 from that edge on.
- R3: Each frame has exactly 16 toggles of `sck_o` while `ss_n_o` is 0. `sck_o` is back at its polarity level when `ss_n_o` rises.
- R4: The first toggle comes D clocks after `ss_n_o` falls. Each later toggle comes D clocks after the one before it. `ss_n_o` rises D clocks after the last toggle. D is `div_i` when `div_i` is 1 or more, and D is 1 when `div_i` is 0.
- R5: Odd-numbered toggles are leading edges. With `cpol_i`=0 a leading edge rises, and with `cpol_i`=1 it falls. With `cpha_i`=0, MISO is sampled on leading edges and MOSI changes only on trailing edges. With `cpha_i`=1 it is the other way round, and the first leading edge does not change MOSI.
- R6: With `cpha_i`=0, MOSI already carries the first bit of the frame in the cycle that `ss_n_o` falls.
- R7: With `lsb_first_i`=0, bits go out and come in from bit 7 down to bit 0. With `lsb_first_i`=1, they go from bit 0 up to bit 7. The same order holds on both MOSI and MISO.
- R8: `done_o` is high for exactly one cycle, in the same cycle that `busy_o` falls and `ss_n_o` rises. In that cycle `rx_byte_o` holds the received byte in natural order, with the first-received bit at bit 7 when `lsb_first_i`=0 and at bit 0 when `lsb_first_i`=1.
- R9: A `start_i` that arrives while busy is ignored. The frame in progress sends and receives its own bytes, and no second frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a frame when the block is idle |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | 0: sample on the leading edge; 1: sample on the trailing edge |
| lsb_first_i | input | 1 | 0: bit 7 goes first; 1: bit 0 goes first |
| div_i | input | DIV_W | Half-period of the serial clock in system clocks (0 is treated as 1) |
| tx_byte_i | input | DATA_W | Byte to send |
| busy_o | output | 1 | High while a frame is active |
| done_o | output | 1 | One-cycle pulse when a frame ends |
| rx_byte_o | output | DATA_W | Last received byte, in natural order |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| ss_n_o | output | 1 | Active-low slave select |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong edge counter shows up as the wrong number of clock toggles, or as a clock left at the wrong level when select rises. Both are visible at the end of the first frame. A half-period counter that reloads wrongly changes the spacing between toggles, which can be seen within a few clocks. A phase or order decode error puts MOSI changes on sample edges, or mirrors or shifts the received and sent bytes. The bench checks every mode and order pair, so such an error shows up in the first frame that uses the broken combination.

// File: rtl/spi_mm_pkg.sv
package spi_mm_pkg;

   typedef struct packed {
      logic cpol;
      logic cpha;
      logic lsb_first;
   } spi_mm_cfg_t;

endpackage

// File: rtl/spi_mm_tick.sv
// Half-period timer: produces one tick every max(div,1) clocks while running.
module spi_mm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] reload_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_m1;

   assign div_m1 = (div == '0) ? '0 : div - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '0;
      end else if (load) begin
         reload_q <= div_m1;
         cnt_q    <= div_m1;
      end else if (run) begin
         if (cnt_q == '0) cnt_q <= reload_q;
         else             cnt_q <= cnt_q - DIV_W'(1);
      end
   end

   assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/spi_mm_shift.sv
// Transmit and receive shift registers; order handled by bit reversal at the edges.
module spi_mm_shift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              ord_load,
   input  logic              ord_q,
   input  logic [DATA_W-1:0] tx,
   input  logic              shift_en,
   input  logic              sample_en,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_nat
);
   logic [DATA_W-1:0] tx_rev;
   logic [DATA_W-1:0] rx_rev;
   logic [DATA_W-1:0] tx_sh_q;
   logic [DATA_W-1:0] rx_sh_q;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign tx_rev[i] = tx[DATA_W-1-i];
      assign rx_rev[i] = rx_sh_q[DATA_W-1-i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q <= '0;
         rx_sh_q <= '0;
      end else begin
         if (load)          tx_sh_q <= ord_load ? tx_rev : tx;
         else if (shift_en) tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
         if (sample_en)     rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
      end
   end

   assign mosi   = tx_sh_q[DATA_W-1];
   assign rx_nat = ord_q ? rx_rev : rx_sh_q;
endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master
   import spi_mm_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cpol_i,
   input  logic              cpha_i,
   input  logic              lsb_first_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              ss_n_o,
   input  logic              miso_i
);
   localparam int EDGES  = 2 * DATA_W;
   localparam int EDGE_W = $clog2(EDGES + 1);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("spi_mode_master: DATA_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div_w
      $error("spi_mode_master: DIV_W must be at least 1");
   end

   spi_mm_cfg_t       cfg_q;
   logic              busy_q, ss_n_q, sck_q, done_q;
   logic [DATA_W-1:0] rx_q;
   logic [EDGE_W-1:0] edge_q;
   logic              accept, tick, leading, last, samp_en, shift_en;
   logic              sh_mosi;
   logic [DATA_W-1:0] rx_nat;

   assign accept  = start_i && !busy_q;
   assign leading = !edge_q[0];
   assign last    = (edge_q == EDGE_W'(EDGES));
   assign samp_en = tick && !last && (cfg_q.cpha ? !leading : leading);
   assign shift_en = tick && !last &&
                     (cfg_q.cpha ? (leading && edge_q != '0) : !leading);

   spi_mm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .run   (busy_q),
      .div   (div_i),
      .tick  (tick)
   );

   spi_mm_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .ord_load  (lsb_first_i),
      .ord_q     (cfg_q.lsb_first),
      .tx        (tx_byte_i),
      .shift_en  (shift_en),
      .sample_en (samp_en),
      .miso      (miso_i),
      .mosi      (sh_mosi),
      .rx_nat    (rx_nat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         busy_q <= 1'b0;
         ss_n_q <= 1'b1;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
         rx_q   <= '0;
         edge_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            cfg_q  <= '{cpol: cpol_i, cpha: cpha_i, lsb_first: lsb_first_i};
            busy_q <= 1'b1;
            ss_n_q <= 1'b0;
            sck_q  <= cpol_i;
            edge_q <= '0;
         end else if (tick) begin
            if (last) begin
               busy_q <= 1'b0;
               ss_n_q <= 1'b1;
               done_q <= 1'b1;
               rx_q   <= rx_nat;
            end else begin
               sck_q  <= ~sck_q;
               edge_q <= edge_q + EDGE_W'(1);
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign rx_byte_o = rx_q;
   assign ss_n_o    = ss_n_q;
   assign sck_o     = busy_q ? sck_q : cpol_i;
   assign mosi_o    = busy_q & sh_mosi;
endmodule

// File: rtl/spi_mm_chk.sv
module spi_mm_chk #(
   parameter int DATA_W = 8
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic busy_o,
   input logic done_o,
   input logic ss_n_o,
   input logic sck_o,
   input logic mosi_o
);
   localparam int EDGE_W = $clog2(2 * DATA_W + 1);

   logic [EDGE_W-1:0] tog_q;
   logic              sck_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q <= '0;
         sck_p <= 1'b0;
      end else begin
         sck_p <= sck_o;
         if (ss_n_o)              tog_q <= '0;
         else if (sck_o != sck_p) tog_q <= tog_q + EDGE_W'(1);
      end
   end

   // R1
   idle_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> ss_n_o);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !ss_n_o));

   // R3
   edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_n_o) |-> (tog_q == EDGE_W'(2 * DATA_W)));

   // R5
   mosi_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ss_n_o && $past(!ss_n_o) && !$stable(mosi_o)) |-> !$stable(sck_o));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o) && ss_n_o));

   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_o) |=> (!ss_n_o || done_o));
endmodule

bind spi_mode_master spi_mm_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .ss_n_o  (ss_n_o),
   .sck_o   (sck_o),
   .mosi_o  (mosi_o)
);

// File: tb/spi_mode_master_tb.sv
module spi_mode_master_tb;
   localparam int CLK_P = 10;
   localparam int NVEC  = 8;

   // {cpol, cpha, lsb_first, div[7:0], tx[7:0], slave byte[7:0]}
   localparam logic [26:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C},
      {1'b0, 1'b1, 1'b0, 8'd2, 8'h5A, 8'hC3},
      {1'b1, 1'b0, 1'b0, 8'd3, 8'h81, 8'h7E},
      {1'b1, 1'b1, 1'b0, 8'd1, 8'h0F, 8'hF0},
      {1'b0, 1'b0, 1'b1, 8'd2, 8'h96, 8'h69},
      {1'b0, 1'b1, 1'b1, 8'd0, 8'h01, 8'h80},
      {1'b1, 1'b0, 1'b1, 8'd4, 8'hC4, 8'h2B},
      {1'b1, 1'b1, 1'b1, 8'd3, 8'hFF, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       cpol_i = 1'b0, cpha_i = 1'b0, lsb_first_i = 1'b0;
   logic [7:0] div_i = 8'd1;
   logic [7:0] tx_byte_i = 8'h00;
   logic       miso_i = 1'b0;
   logic       busy_o, done_o, sck_o, mosi_o, ss_n_o;
   logic [7:0] rx_byte_o;

   int checks = 0;
   int fails  = 0;

   // monitor / slave model state
   int cyc = 0, m_edges = 0, m_gaperr = 0, m_direrr = 0, m_mosierr = 0;
   int m_last = 0, m_idx = 0, m_ns = 0;
   logic [7:0] m_cap = 8'h00;
   logic p_ss = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;
   logic c_cpol = 1'b0, c_cpha = 1'b0, c_lsb = 1'b0;
   int c_d = 1;
   logic [7:0] c_slv = 8'h00;

   always #(CLK_P/2) clk = ~clk;

   spi_mode_master u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cpol_i(cpol_i),
      .cpha_i(cpha_i), .lsb_first_i(lsb_first_i), .div_i(div_i),
      .tx_byte_i(tx_byte_i), .busy_o(busy_o), .done_o(done_o),
      .rx_byte_o(rx_byte_o), .sck_o(sck_o), .mosi_o(mosi_o),
      .ss_n_o(ss_n_o), .miso_i(miso_i)
   );

   function automatic logic bit_at(input logic [7:0] b, input int k, input logic lsb);
      if (k > 7) return 1'b0;
      return lsb ? b[k] : b[7-k];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bus monitor and slave model, evaluated away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (p_ss && !ss_n_o) begin
         m_edges = 0; m_idx = 0; m_ns = 0; m_last = cyc;
         miso_i = bit_at(c_slv, 0, c_lsb);
      end else if (!ss_n_o) begin
         if (sck_o != p_sck) begin
            m_edges++;
            if (cyc - m_last != c_d) m_gaperr++;
            m_last = cyc;
            if (sck_o != (m_edges[0] ? !c_cpol : c_cpol)) m_direrr++;
            if (c_cpha ? !m_edges[0] : m_edges[0]) begin
               if (mosi_o != p_mosi) m_mosierr++;
               if (m_ns < 8) m_cap[c_lsb ? m_ns : 7 - m_ns] = mosi_o;
               m_ns++;
            end else if (c_cpha && m_edges == 1) begin
               if (mosi_o != p_mosi) m_mosierr++;
               miso_i = bit_at(c_slv, 0, c_lsb);
            end else begin
               m_idx++;
               miso_i = bit_at(c_slv, m_idx, c_lsb);
            end
         end else if (mosi_o != p_mosi) begin
            m_mosierr++;
         end
      end else if (!p_ss && ss_n_o) begin
         if (cyc - m_last != c_d) m_gaperr++;
      end
      p_ss = ss_n_o; p_sck = sck_o; p_mosi = mosi_o;
   end

   task automatic run_frame(input logic p, input logic h, input logic l,
                            input logic [7:0] d, input logic [7:0] tx,
                            input logic [7:0] slv, input int intr_at);
      int n;
      @(negedge clk);
      c_cpol = p; c_cpha = h; c_lsb = l; c_slv = slv;
      c_d = (d == 8'd0) ? 1 : int'(d);
      m_gaperr = 0; m_direrr = 0; m_mosierr = 0; m_cap = 8'h00;
      cpol_i = p; cpha_i = h; lsb_first_i = l; div_i = d; tx_byte_i = tx;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && !ss_n_o, "R2 busy/select after start", {busy_o, ss_n_o}, 2'b10);
      if (!h) chk(mosi_o == bit_at(tx, 0, l), "R6 first bit at select", mosi_o, bit_at(tx, 0, l));
      // scramble live settings: captured values must govern the frame
      cpol_i = ~p; cpha_i = ~h; lsb_first_i = ~l; div_i = d + 8'd1; tx_byte_i = ~tx;
      n = 0;
      while (!done_o && n < 5000) begin
         if (intr_at > 0 && n == intr_at) start_i = 1'b1;
         if (intr_at > 0 && n == intr_at + 1) start_i = 1'b0;
         @(negedge clk);
         n++;
      end
      start_i = 1'b0;
      chk(done_o == 1'b1, "R8 done reached", done_o, 1);
      chk(rx_byte_o == slv, "R8 R7 received byte", rx_byte_o, slv);
      chk(!busy_o && ss_n_o, "R8 busy low with done", {busy_o, ss_n_o}, 2'b01);
      cpol_i = p;
      @(negedge clk);
      chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
      chk(m_edges == 16, "R3 toggle count", m_edges, 16);
      chk(sck_o == p, "R3 idle level after frame", sck_o, p);
      chk(m_gaperr == 0, "R4 half-period spacing", m_gaperr, 0);
      chk(m_direrr == 0, "R5 edge direction", m_direrr, 0);
      chk(m_mosierr == 0, "R5 MOSI changes on setup edges", m_mosierr, 0);
      chk(m_cap == tx, "R7 transmitted byte", m_cap, tx);
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(ss_n_o && !busy_o && !done_o && sck_o == 1'b0, "R1 reset state",
          {ss_n_o, busy_o, done_o, sck_o}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      cpol_i = 1'b1;
      @(negedge clk);
      chk(sck_o == 1'b1 && ss_n_o, "R1 idle clock follows polarity", sck_o, 1);
      cpol_i = 1'b0;
      @(negedge clk);
      chk(sck_o == 1'b0, "R1 idle clock low", sck_o, 0);

      for (int i = 0; i < NVEC; i++) begin
         run_frame(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16],
                   VEC[i][15:8], VEC[i][7:0], 0);
      end

      // R9: start during a frame is ignored
      run_frame(1'b0, 1'b0, 1'b0, 8'd2, 8'h3A, 8'hD5, 9);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(ss_n_o && !busy_o, "R9 no second frame", {ss_n_o, busy_o}, 2'b10);
      end
      run_frame(1'b1, 1'b1, 1'b1, 8'd1, 8'h6C, 8'h93, 20);

      // R4 boundary: largest tested half-period with back-to-back frames
      run_frame(1'b0, 1'b1, 1'b0, 8'd5, 8'hE1, 8'h1E, 0);
      run_frame(1'b0, 1'b1, 1'b0, 8'd1, 8'h1E, 8'hE1, 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule